// File: doc/BRIEF.md
# Clock-Crossing APB Register Port

This block is an APB subordinate whose register storage runs on a second clock. The APB-facing half lives on the bus clock. It accepts one access at a time and keeps its address, write data and direction in a holding register. It tells the storage half that work is waiting by flipping a single request toggle. The storage half sits on the core clock and holds four 32-bit registers. It sees the toggle through a two-flop synchroniser, performs the access, registers its read data and error bit, and then flips a done toggle. That toggle is brought back through another two-flop synchroniser. Only then does the bus side raise PREADY.

The wait is therefore not a fixed count. It varies with the phase of the two clocks, but it is always bounded. It is made of two synchroniser delays plus one core-clock cycle of work. No part of it waits on an event that might never come.

Back-pressure uses the APB handshake itself. PREADY is the ready signal for an access phase (PSEL and PENABLE both high), and it is driven low in every other cycle. The manager must hold PSEL, PENABLE, PADDR, PWRITE and PWDATA stable until it samples PREADY high. Exactly one ready cycle is given per access.

Top module: `cdc_apb_regfile`

## Requirements
- R1: After reset, pready, prdata and pslverr are 0, and all four registers read back as 0.
- R2: pready is 0 in every cycle in which psel or penable is 0, including the setup cycle.
- R3: pready is never high in the first access-phase cycle. At least 2 wait cycles always pass, because the request and the done indication each cross a two-flop synchroniser.
- R4: Every access sees pready high within WAIT_BOUND (default 24) access-phase cycles that have pready low. A core clock up to about three times slower than the bus clock meets this bound.
- R5: An access is in range when paddr[11:4] is 0. It selects register paddr[3:2]; paddr[1:0] is ignored. An in-range write stores pwdata in that register. An in-range read returns the register value. Both complete with pslverr 0, and a write completes with prdata 0.
- R6: An out-of-range access completes with pslverr 1 and prdata 0, and it changes no register.
- R7: prdata and pslverr are valid in the cycle pready is high. They keep that value until the next access completes.
- R8: pready is high for exactly one cycle per access, and it is low in the cycle after. A new request is not launched until the previous done toggle has been seen.
- R9: The request held for the core domain does not change between launch and the return of the done toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low |
| cclk | input | 1 | Core clock of the register storage |
| crst_n | input | 1 | Core-domain reset, active low, already synchronised |
| psel | input | 1 | Subordinate select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid with pready |
| pready | output | 1 | Access completion |
| pslverr | output | 1 | Error flag, valid with pready |

## Verification
The two clocks are unrelated, so the exact completion cycle cannot be predicted. Each result is instead due in the one bus cycle where pready is high. The bench samples pready, prdata and pslverr at the falling edge of every access-phase cycle. It counts the low cycles and checks that the count falls between 2 and WAIT_BOUND. It compares data and the error flag only in the ready cycle. The cycle after each completion, and a few idle cycles later, are sampled to confirm that pready has dropped and that prdata has held its value.

// File: rtl/cdc_apb_pkg.sv
package cdc_apb_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int NREG    = 4;
  localparam int IDX_LSB = 2;
  localparam int IDX_W   = $clog2(NREG);
  localparam int HI_LSB  = IDX_LSB + IDX_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              write;
  } xreq_t;
endpackage

// File: rtl/cdc_apb_tsync.sv
module cdc_apb_tsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cdc_apb_far.sv
module cdc_apb_far
  import cdc_apb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              cclk,
  input  logic              crst_n,
  input  logic              req_tgl,
  input  xreq_t             req,
  output logic              done_tgl,
  output logic [DATA_W-1:0] rdata_q,
  output logic              err_q
);
  logic req_s, req_seen, go, hit;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] regs [NREG];

  cdc_apb_tsync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(cclk), .rst_n(crst_n), .d(req_tgl), .q(req_s)
  );

  assign go  = req_s != req_seen;
  assign hit = req.addr[ADDR_W-1:HI_LSB] == '0;
  assign idx = req.addr[HI_LSB-1:IDX_LSB];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge cclk or negedge crst_n) begin
        if (!crst_n) regs[g] <= '0;
        else if (go && hit && req.write && idx == g) regs[g] <= req.wdata;
      end
    end
  endgenerate

  always_ff @(posedge cclk or negedge crst_n) begin
    if (!crst_n) begin
      req_seen <= 1'b0;
      done_tgl <= 1'b0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
    end else if (go) begin
      req_seen <= req_s;
      rdata_q  <= (hit && !req.write) ? regs[idx] : '0;
      err_q    <= !hit;
      done_tgl <= ~done_tgl;
    end
  end

  // R6: an out-of-range request leaves every register untouched
  p_oob_keep_r6: assert property (@(posedge cclk) disable iff (!crst_n)
    (go && !hit) |=> ($stable(regs[0]) && $stable(regs[1]) &&
                      $stable(regs[2]) && $stable(regs[3])));

  // R3: the done toggle moves only after a synchronised request was taken
  p_done_after_req_r3: assert property (@(posedge cclk) disable iff (!crst_n)
    (done_tgl != $past(done_tgl)) |-> $past(go));
endmodule

// File: rtl/cdc_apb_near.sv
module cdc_apb_near
  import cdc_apb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_BOUND  = 24
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              req_tgl,
  output xreq_t             req_q,
  input  logic              done_tgl,
  input  logic [DATA_W-1:0] far_rdata,
  input  logic              far_err
);
  localparam int CNT_W = $clog2(WAIT_BOUND + 2) + 1;

  logic busy, cmpl, done_s, done_seen, access, launch, ret;
  logic [CNT_W-1:0] wait_cnt;

  cdc_apb_tsync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(pclk), .rst_n(presetn), .d(done_tgl), .q(done_s)
  );

  assign access = psel && penable;
  assign launch = access && !busy && !cmpl;
  assign ret    = busy && (done_s != done_seen);
  assign pready = access && cmpl;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      busy      <= 1'b0;
      cmpl      <= 1'b0;
      req_tgl   <= 1'b0;
      req_q     <= '0;
      done_seen <= 1'b0;
      prdata    <= '0;
      pslverr   <= 1'b0;
    end else begin
      if (launch) begin
        req_q   <= '{addr: paddr, wdata: pwdata, write: pwrite};
        req_tgl <= ~req_tgl;
        busy    <= 1'b1;
      end
      if (ret) begin
        done_seen <= done_s;
        busy      <= 1'b0;
        cmpl      <= 1'b1;
        prdata    <= far_rdata;
        pslverr   <= far_err;
      end
      if (pready) cmpl <= 1'b0;
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)             wait_cnt <= '0;
    else if (!access)         wait_cnt <= '0;
    else if (!pready && wait_cnt <= CNT_W'(WAIT_BOUND)) wait_cnt <= wait_cnt + 1'b1;
  end

  // R9: held request is frozen while the far side may be reading it
  p_hold_req_r9: assert property (@(posedge pclk) disable iff (!presetn)
    (busy && $past(busy)) |-> $stable(req_q));

  // R8: no second launch while one is outstanding
  p_no_relaunch_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (busy && $past(busy)) |-> (req_tgl == $past(req_tgl)));

  // R8: a single ready cycle per access
  p_ready_once_r8: assert property (@(posedge pclk) disable iff (!presetn)
    pready |=> !pready);

  // R4: wait length stays within the bound
  p_wait_bound_r4: assert property (@(posedge pclk) disable iff (!presetn)
    wait_cnt <= CNT_W'(WAIT_BOUND));
endmodule

// File: rtl/cdc_apb_regfile.sv
module cdc_apb_regfile
  import cdc_apb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_BOUND  = 24
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              cclk,
  input  logic              crst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr
);
  logic              req_tgl, done_tgl, far_err;
  xreq_t             req_q;
  logic [DATA_W-1:0] far_rdata;

  cdc_apb_near #(.SYNC_STAGES(SYNC_STAGES), .WAIT_BOUND(WAIT_BOUND)) u_near (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .req_tgl(req_tgl), .req_q(req_q),
    .done_tgl(done_tgl), .far_rdata(far_rdata), .far_err(far_err)
  );

  cdc_apb_far #(.SYNC_STAGES(SYNC_STAGES)) u_far (
    .cclk(cclk), .crst_n(crst_n), .req_tgl(req_tgl), .req(req_q),
    .done_tgl(done_tgl), .rdata_q(far_rdata), .err_q(far_err)
  );

  // R2: never ready outside an access phase
  p_idle_low_r2: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable) |-> !pready);
endmodule

// File: tb/cdc_apb_regfile_tb_top.sv
module cdc_apb_regfile_tb_top;
  localparam int BOUND = 24;

  logic pclk = 0, cclk = 0, presetn = 0, crst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr;

  int nchk = 0, nerr = 0;
  logic [31:0] mdl [4];

  always #2.5 pclk = ~pclk;
  always #6.5 cclk = ~cclk;

  cdc_apb_regfile #(.WAIT_BOUND(BOUND)) dut_i (
    .pclk(pclk), .presetn(presetn), .cclk(cclk), .crst_n(crst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  function automatic bit in_range(input logic [11:0] a);
    return a[11:4] == '0;
  endfunction

  function automatic logic [31:0] exp_rd(input logic wr, input logic [11:0] a);
    return (!wr && in_range(a)) ? mdl[a[3:2]] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d);
    int waits = 0;
    logic [31:0] er = exp_rd(wr, a);
    bit ee = !in_range(a);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    #0.1 check(pready == 0, "R2 setup cycle", 32'(pready), 0);
    @(negedge pclk);
    penable = 1;
    #0.1;
    while (!pready && waits < 1000) begin
      waits++;
      @(negedge pclk); #0.1;
    end
    check(waits >= 2, "R3 min waits", waits, 2);
    check(waits <= BOUND, "R4 wait bound", waits, BOUND);
    check(prdata == er, wr ? "R5/R6 write rdata" : "R5/R6 read data", prdata, er);
    check(pslverr == ee, "R6 error flag", 32'(pslverr), 32'(ee));
    if (wr && !ee) mdl[a[3:2]] = d;
    @(negedge pclk);
    psel = 0; penable = 0;
    #0.1 check(pready == 0, "R8 single ready", 32'(pready), 0);
    check(prdata == er, "R7 data held", prdata, er);
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    repeat (4) @(negedge cclk);
    crst_n = 1;
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    check(pready == 0 && pslverr == 0, "R1 reset outputs", {pready, pslverr}, 0);
    check(prdata == 0, "R1 reset prdata", prdata, 0);
    for (int i = 0; i < 4; i++) xfer(0, 12'(i * 4), 0);        // R1 readback zero

    for (int i = 0; i < 4; i++) xfer(1, 12'(i * 4 + i), 32'hA5000000 + i); // R5
    for (int i = 0; i < 4; i++) xfer(0, 12'(i * 4), 0);

    xfer(1, 12'h010, 32'hDEADBEEF);                            // R6
    xfer(1, 12'h804, 32'h12345678);
    xfer(0, 12'hFFC, 0);
    for (int i = 0; i < 4; i++) xfer(0, 12'(i * 4), 0);        // R6 no change

    repeat (6) begin
      @(negedge pclk);
      check(pready == 0, "R2 idle low", 32'(pready), 0);
    end
    check(prdata == mdl[3], "R7 idle hold", prdata, mdl[3]);

    for (int n = 0; n < 150; n++) begin
      logic [11:0] a;
      if (($urandom % 5) != 0) a = 12'($urandom % 16);
      else a = 12'($urandom);
      xfer(1'($urandom), a, $urandom);
      if (($urandom % 4) == 0) repeat ($urandom % 5) @(negedge pclk);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule